// File: doc/BRIEF.md
# Clock Source Mode Controller

This block picks which of three sources drives the CPU clock and controls the two oscillators it owns. The three sources are a main external oscillator, an internal ring oscillator and a subsystem clock. Software writes a single control word through a plain write strobe. The block checks each write against the mode it is in. Fields that would cause an illegal transition or an illegal stop are dropped without any notice. The accepted fields drive a small mode sequencer.

The outputs are two status flags, a two-bit select code for an external clock multiplexer, and an enable for each oscillator. All outputs come from flops. Only the switch into main-oscillator mode waits, and it waits for a ready input from the main oscillator. Glitch-free switching, start-up counting and analog behaviour belong to other blocks.

Top module: `clksrc_mode_ctrl`

## Requirements
- R1: After reset the block is in ring mode: `stat_sub`=0, `stat_main`=0, `clk_sel`=0, `main_osc_en`=1, `ring_osc_en`=1.
- R2: Mode encoding is `{stat_sub,stat_main}`/`clk_sel` = 00/0 for ring mode, 01/1 for main mode and 11/2 for subsystem mode. The status value 10 never appears.
- R3: Control word fields are as follows. Bit 0 requests main. Bit 1 requests subsystem and overrides bit 0. With neither bit set, the request is ring. Bit 2 is the main-oscillator halt that counts in ring mode. Bit 3 is the main-oscillator halt that counts in subsystem mode. Bit 4 is the ring-oscillator halt. A halt bit of 1 stops the oscillator and 0 restarts it.
- R4: An accepted main request moves the status to main at the first clock edge at which `main_osc_ready` is sampled high, counting the edge that accepts the write. Until then the status shows the previous mode.
- R5: Subsystem mode can be entered only from main mode, and it is entered at the edge that accepts the write. A subsystem request in ring mode is ignored.
- R6: Subsystem mode can be left only toward main mode. A ring request in subsystem mode is ignored.
- R7: Bit 2 takes effect only in ring mode when the target stays ring. Bit 3 takes effect only in subsystem mode when the target stays subsystem. In every other case both bits leave `main_osc_en` as it is.
- R8: In main mode, or while main is the target, `main_osc_en` is 1. Accepting a main target re-enables the main oscillator.
- R9: Bit 4 takes effect only when `ring_stop_allowed` is 1, the mode is not ring and the new target is not ring. Accepting a ring target, or `ring_stop_allowed`=0, sets `ring_osc_en` to 1.
- R10: A switch from main to ring, or from main to subsystem, appears at the outputs at the edge that samples the write.
- R11: A new accepted request made while a main switch is pending replaces the pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | CTRL_W | Control word (fields per R3) |
| ring_stop_allowed | input | 1 | Static option: software may stop the ring oscillator |
| main_osc_ready | input | 1 | Main oscillator is stable |
| main_osc_en | output | 1 | Main oscillator run enable |
| ring_osc_en | output | 1 | Ring oscillator run enable |
| clk_sel | output | 2 | Clock multiplexer select code |
| stat_sub | output | 1 | Status: subsystem clock active |
| stat_main | output | 1 | Status: main or subsystem clock active |

## Verification
A wrong internal mode or target shows up at the status and select pins at the first edge where a legal and an illegal request get different treatment. A pending main switch is the main exception. The target is not visible at the ports, so a target error appears only when `main_osc_ready` rises, or as a main enable that ought to be forced high. A wrong halt-bit state shows on the matching enable pin one edge after the write that reveals it. The bench therefore compares every output after every edge, across long random runs where readiness and the ring-stop option keep changing.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
  typedef enum logic [1:0] {
    MODE_RING = 2'd0,
    MODE_MAIN = 2'd1,
    MODE_SUB  = 2'd2
  } mode_e;

  localparam int unsigned FLD_W       = 5;
  localparam int unsigned B_SEL_MAIN  = 0;
  localparam int unsigned B_SEL_SUB   = 1;
  localparam int unsigned B_HALT_RP   = 2;
  localparam int unsigned B_HALT_SP   = 3;
  localparam int unsigned B_HALT_RING = 4;

  typedef struct packed {
    mode_e sel;
    logic  halt_main_rp;
    logic  halt_main_sp;
    logic  halt_ring;
  } ctl_req_t;
endpackage

// File: rtl/clksrc_req_decode.sv
module clksrc_req_decode
  import clksrc_pkg::*;
#(
  parameter int unsigned CTRL_W = FLD_W
) (
  input  logic [CTRL_W-1:0] wr_data,
  output ctl_req_t          req
);
  always_comb begin
    if (wr_data[B_SEL_SUB])       req.sel = MODE_SUB;
    else if (wr_data[B_SEL_MAIN]) req.sel = MODE_MAIN;
    else                          req.sel = MODE_RING;
    req.halt_main_rp = wr_data[B_HALT_RP];
    req.halt_main_sp = wr_data[B_HALT_SP];
    req.halt_ring    = wr_data[B_HALT_RING];
  end
endmodule

// File: rtl/clksrc_policy.sv
module clksrc_policy
  import clksrc_pkg::*;
(
  input  mode_e    mode_q,
  input  mode_e    tgt_q,
  input  logic     mstop_q,
  input  logic     rstop_q,
  input  logic     wr_en,
  input  ctl_req_t req,
  input  logic     ring_stop_allowed,
  output mode_e    tgt_d,
  output logic     mstop_d,
  output logic     rstop_d
);
  always_comb begin
    tgt_d   = tgt_q;
    mstop_d = mstop_q;
    rstop_d = rstop_q;
    if (wr_en) begin
      // legal transition graph: ring<->main<->sub
      case (mode_q)
        MODE_RING: if (req.sel != MODE_SUB)  tgt_d = req.sel;
        MODE_MAIN: tgt_d = req.sel;
        MODE_SUB:  if (req.sel != MODE_RING) tgt_d = req.sel;
        default:   tgt_d = tgt_q;
      endcase
      // main-oscillator halt: a different bit is legal per mode
      if (tgt_d == MODE_MAIN)
        mstop_d = 1'b0;
      else if (mode_q == MODE_RING && tgt_d == MODE_RING)
        mstop_d = req.halt_main_rp;
      else if (mode_q == MODE_SUB && tgt_d == MODE_SUB)
        mstop_d = req.halt_main_sp;
      // ring-oscillator halt: never while ring is active or targeted
      if (tgt_d == MODE_RING)
        rstop_d = 1'b0;
      else if (mode_q != MODE_RING)
        rstop_d = req.halt_ring;
    end
    if (!ring_stop_allowed) rstop_d = 1'b0;
  end
endmodule

// File: rtl/clksrc_mode_seq.sv
module clksrc_mode_seq
  import clksrc_pkg::*;
#(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_e            tgt_d,
  input  logic             mstop_d,
  input  logic             rstop_d,
  input  logic             main_osc_ready,
  output mode_e            mode_q,
  output mode_e            tgt_q,
  output logic             mstop_q,
  output logic             rstop_q,
  output logic [SEL_W-1:0] clk_sel,
  output logic             stat_sub,
  output logic             stat_main
);
  mode_e mode_d;

  always_comb begin
    if (tgt_d == MODE_MAIN)
      mode_d = (mode_q == MODE_MAIN || main_osc_ready) ? MODE_MAIN : mode_q;
    else
      mode_d = tgt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RING;
      tgt_q   <= MODE_RING;
      mstop_q <= 1'b0;
      rstop_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      tgt_q   <= tgt_d;
      mstop_q <= mstop_d;
      rstop_q <= rstop_d;
    end
  end

  assign clk_sel   = SEL_W'(mode_q);
  assign stat_sub  = (mode_q == MODE_SUB);
  assign stat_main = (mode_q != MODE_RING);
endmodule

// File: rtl/clksrc_mode_ctrl.sv
module clksrc_mode_ctrl
  import clksrc_pkg::*;
#(
  parameter int unsigned CTRL_W = FLD_W,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              ring_stop_allowed,
  input  logic              main_osc_ready,
  output logic              main_osc_en,
  output logic              ring_osc_en,
  output logic [SEL_W-1:0]  clk_sel,
  output logic              stat_sub,
  output logic              stat_main
);
  ctl_req_t req;
  mode_e    mode_q, tgt_q, tgt_d;
  logic     mstop_q, rstop_q, mstop_d, rstop_d;

  clksrc_req_decode #(.CTRL_W(CTRL_W)) u_dec (
    .wr_data (wr_data),
    .req     (req)
  );

  clksrc_policy u_pol (
    .mode_q            (mode_q),
    .tgt_q             (tgt_q),
    .mstop_q           (mstop_q),
    .rstop_q           (rstop_q),
    .wr_en             (wr_en),
    .req               (req),
    .ring_stop_allowed (ring_stop_allowed),
    .tgt_d             (tgt_d),
    .mstop_d           (mstop_d),
    .rstop_d           (rstop_d)
  );

  clksrc_mode_seq #(.SEL_W(SEL_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .tgt_d          (tgt_d),
    .mstop_d        (mstop_d),
    .rstop_d        (rstop_d),
    .main_osc_ready (main_osc_ready),
    .mode_q         (mode_q),
    .tgt_q          (tgt_q),
    .mstop_q        (mstop_q),
    .rstop_q        (rstop_q),
    .clk_sel        (clk_sel),
    .stat_sub       (stat_sub),
    .stat_main      (stat_main)
  );

  assign main_osc_en = ~mstop_q;
  assign ring_osc_en = ~rstop_q;
endmodule

// File: rtl/clksrc_mode_ctrl_chk.sv
module clksrc_mode_ctrl_chk #(
  parameter int unsigned SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ring_stop_allowed,
  input logic             main_osc_ready,
  input logic             main_osc_en,
  input logic             ring_osc_en,
  input logic [SEL_W-1:0] clk_sel,
  input logic             stat_sub,
  input logic             stat_main
);
  logic       past_ok;
  logic [1:0] st;
  assign st = {stat_sub, stat_main};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  p_no_bad_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st != 2'b10);

  p_sub_from_main_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && st == 2'b11 && $past(st) != 2'b11) |-> $past(st) == 2'b01);

  p_sub_exit_main_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && st != 2'b11 && $past(st) == 2'b11) |-> st == 2'b01);

  p_main_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && st == 2'b01 && $past(st) != 2'b01) |-> $past(main_osc_ready));

  p_main_runs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st == 2'b01 |-> main_osc_en);

  p_ring_runs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st == 2'b00 |-> ring_osc_en);

  p_ring_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ring_stop_allowed |=> ring_osc_en);

  p_sel_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == SEL_W'(0)) == (st == 2'b00));
endmodule

bind clksrc_mode_ctrl clksrc_mode_ctrl_chk #(.SEL_W(SEL_W)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .ring_stop_allowed (ring_stop_allowed),
  .main_osc_ready    (main_osc_ready),
  .main_osc_en       (main_osc_en),
  .ring_osc_en       (ring_osc_en),
  .clk_sel           (clk_sel),
  .stat_sub          (stat_sub),
  .stat_main         (stat_main)
);

// File: tb/clksrc_mode_ctrl_bench.sv
module clksrc_mode_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_data = '0;
  logic       ring_stop_allowed = 1'b1;
  logic       main_osc_ready = 1'b0;
  logic       main_osc_en, ring_osc_en, stat_sub, stat_main;
  logic [1:0] clk_sel;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  // model: 0 ring, 1 main, 2 sub
  int m_mode = 0, m_tgt = 0;
  bit m_mstop = 0, m_rstop = 0;

  always #4 clk = ~clk;

  clksrc_mode_ctrl u_clksrc_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ring_stop_allowed(ring_stop_allowed), .main_osc_ready(main_osc_ready),
    .main_osc_en(main_osc_en), .ring_osc_en(ring_osc_en), .clk_sel(clk_sel),
    .stat_sub(stat_sub), .stat_main(stat_main)
  );

  function automatic int sel_of(logic [4:0] d);  // R3
    return d[1] ? 2 : (d[0] ? 1 : 0);
  endfunction

  function automatic logic [1:0] stat_of(int m);  // R2
    return (m == 0) ? 2'b00 : (m == 1) ? 2'b01 : 2'b11;
  endfunction

  task automatic model_step(bit w, logic [4:0] d, bit rdy, bit allow);
    int s;
    if (w) begin
      s = sel_of(d);
      if (m_mode == 1) m_tgt = s;                 // R10
      else if (m_mode == 0 && s != 2) m_tgt = s;  // R5
      else if (m_mode == 2 && s != 0) m_tgt = s;  // R6
      if (m_tgt == 1) m_mstop = 0;                // R8
      else if (m_mode == 0 && m_tgt == 0) m_mstop = d[2];  // R7
      else if (m_mode == 2 && m_tgt == 2) m_mstop = d[3];
      if (m_tgt == 0) m_rstop = 0;                // R9
      else if (m_mode != 0) m_rstop = d[4];
    end
    if (!allow) m_rstop = 0;
    if (m_tgt == 1) begin
      if (rdy) m_mode = 1;                        // R4, R11
    end else m_mode = m_tgt;
  endtask

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " status"}, {stat_sub, stat_main}, stat_of(m_mode));
    chk({tag, " clk_sel"}, clk_sel, m_mode);
    chk({tag, " main_en"}, main_osc_en, !m_mstop);
    chk({tag, " ring_en"}, ring_osc_en, !m_rstop);
  endtask

  task automatic step(bit w, logic [4:0] d, string tag);
    wr_en = w; wr_data = d;
    @(posedge clk);
    model_step(w, d, main_osc_ready, ring_stop_allowed);
    #1;
    chk_all(tag);
    wr_en = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C1_5EED));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 status", {stat_sub, stat_main}, 0);
    chk("R1 enables", {main_osc_en, ring_osc_en}, 3);
    rst_n = 1'b1;
    step(0, 5'h00, "R1 idle");
    chk("R1 clk_sel", clk_sel, 0);
    // directed corner cases
    step(1, 5'h02, "R5 sub from ring ignored");
    step(1, 5'h10, "R9 ring halt while ring active");
    step(1, 5'h08, "R7 sub-path halt in ring");
    step(1, 5'h04, "R7 ring-path halt in ring");
    chk("R7 main stopped", main_osc_en, 0);
    step(1, 5'h01, "R8 main target re-enables");
    step(0, 5'h00, "R4 pending, not ready");
    step(0, 5'h00, "R4 pending, not ready");
    chk("R4 still ring", {stat_sub, stat_main}, 0);
    main_osc_ready = 1'b1;
    step(0, 5'h00, "R4 ready completes");
    chk("R2 main code", clk_sel, 1);
    step(1, 5'h06, "R10 main to sub immediate");
    chk("R2 sub code", {stat_sub, stat_main}, 3);
    step(1, 5'h00, "R6 ring from sub ignored");
    step(1, 5'h06, "R7 ring-path halt in sub");
    step(1, 5'h0A, "R7 sub-path halt in sub");
    step(1, 5'h12, "R9 ring halt in sub");
    chk("R9 ring stopped", ring_osc_en, 0);
    main_osc_ready = 1'b0;
    step(1, 5'h01, "R4 sub to main pending");
    step(1, 5'h02, "R11 cancel pending main");
    main_osc_ready = 1'b1;
    step(0, 5'h00, "R11 stays sub");
    step(1, 5'h11, "R4 sub to main ready");
    step(1, 5'h00, "R10 main to ring immediate");
    step(1, 5'h01, "R4 back to main");
    ring_stop_allowed = 1'b0;
    step(1, 5'h11, "R9 ring halt locked");
    chk("R9 ring locked", ring_osc_en, 1);
    ring_stop_allowed = 1'b1;
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] d;
      d = 5'($urandom);
      if ($urandom_range(3) == 0) d[1] = 1'b0;
      main_osc_ready = ($urandom_range(3) != 0);
      if (i % 700 == 350) ring_stop_allowed = ~ring_stop_allowed;
      step($urandom_range(2) != 0, d, "R3 random");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule